// File: doc/BRIEF.md
# Video Memory Access Sequencer

This block owns every access to a dedicated video DRAM that serves a display controller with two one-way data paths. Time is cut into fixed four-clock access slots. At each slot boundary a fixed two-level arbiter picks an owner. A display fetch request always wins. Host work uses only the slots the display leaves idle: first a held host write, then a host read prefetch. The chosen address goes out on a single multiplexed address bus, qualified first by a row strobe and then by a column strobe. A write also asserts a write strobe.

A display fetch gives either a direct address or a pointer byte. A pointer byte is added to one of several base registers, and the sum is issued in the slot that starts on the next clock. The fetched byte comes back on a dedicated display read bus. Host writes go through a one-entry holding register, and a busy flag stalls further writes. Host reads are served from a one-byte buffer. That buffer is refilled by a prefetch at the shared auto-increment pointer, and a prefetch starts only while the picture is blanked, so back-to-back host reads return consecutive bytes.

Top module: `vram_seq`

## Requirements
- R1: Each access lasts four clocks, counted as slot clocks 0 to 3. `slot_open` is high on clock 3 of every slot. In a slot with an owner, `dram_ma` carries the row half (address bits 13:7) on clocks 0 and 1 and the column half (bits 6:0) on clocks 2 and 3. `dram_ras_n` is low on clocks 1 and 2. `dram_cas_n` is low only on clock 2. In a slot with no owner, all strobes stay high.
- R2: A `disp_req` sampled on a `slot_open` clock is always granted that slot, whatever host work is pending. The fetched byte appears on `disp_rdata` with `disp_rvalid` high on the `slot_open` clock four clocks later. No amount of host traffic delays it.
- R3: With `disp_fwd`=0 the fetch address is `disp_addr`. With `disp_fwd`=1 it is base register `disp_bsel` plus the zero-extended `disp_ptr`, taken modulo 2^14.
- R4: When `base_we` is high, base register `base_idx` takes the value on `base_val` at the clock edge.
- R5: `host_wr` while `host_busy` is low captures `host_wdata`, and `host_busy` is high on the next clock. The write runs in the next slot the display does not claim, at the pointer address, with `dram_we_n` low on the column-strobe clock and the data on `dram_dout`. `host_busy` then falls.
- R6: `host_wr` while `host_busy` is high is ignored. The held data is not replaced, and no extra memory write or pointer step follows.
- R7: `host_aset` loads the 14-bit pointer from `host_aval`, empties the read buffer and requests a prefetch. The pointer steps by one after each completed host write and at each prefetch issue.
- R8: A prefetch is never issued while `active` is high. Host writes still proceed during the active picture.
- R9: When `host_rvalid` is high, `host_rdata` holds the byte from the prefetched address. A `host_rd` pulse empties the buffer and requests the prefetch of the next sequential address.
- R10: When a host write and a prefetch are both pending in a free slot, the write is served first.
- R11: `host_rd` while `host_rvalid` is low is ignored, so no address is skipped.
- R12: After reset all DRAM strobes are high, and `host_busy`, `host_rvalid` and `disp_rvalid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| active | input | 1 | High during the active picture; blocks prefetch |
| disp_req | input | 1 | Display fetch request, sampled on slot_open |
| disp_fwd | input | 1 | 1 selects base-plus-pointer addressing |
| disp_addr | input | 14 | Direct fetch address |
| disp_ptr | input | 8 | Pointer byte for forwarded addressing |
| disp_bsel | input | 2 | Base register select |
| slot_open | output | 1 | Last clock of a slot; requests are sampled here |
| disp_rvalid | output | 1 | Display read data valid |
| disp_rdata | output | 8 | Display read data bus |
| base_we | input | 1 | Base register write enable |
| base_idx | input | 2 | Base register index |
| base_val | input | 14 | Base register value |
| host_wr | input | 1 | Host write pulse |
| host_wdata | input | 8 | Host write data |
| host_busy | output | 1 | Host write held, not yet done |
| host_aset | input | 1 | Load host pointer |
| host_aval | input | 14 | New host pointer value |
| host_rd | input | 1 | Host takes the buffered byte |
| host_rvalid | output | 1 | Read buffer holds a byte |
| host_rdata | output | 8 | Read buffer byte |
| dram_ma | output | 7 | Multiplexed row/column address |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write strobe, active low |
| dram_dout | output | 8 | Write data to DRAM |
| dram_din | input | 8 | Read data from DRAM |

## Verification
A wrong slot phase shows within one slot as a strobe on the wrong clock or a column half on the address bus while the row strobe is still high. A wrong owner register shows at the next `slot_open` as a missing `disp_rvalid`, or as a host write that ends up in memory while the display held every slot. A pointer that steps twice or misses a step is seen at the next buffered read, which returns a byte from the wrong address. A base register or adder fault shows at once as forwarded data that does not match base plus pointer.

// File: rtl/vram_seq_pkg.sv
package vram_seq_pkg;

    typedef enum logic [1:0] {
        OWN_NONE = 2'd0,
        OWN_DISP = 2'd1,
        OWN_HWR  = 2'd2,
        OWN_PF   = 2'd3
    } owner_e;

    localparam logic [1:0] PH_ROW  = 2'd0;
    localparam logic [1:0] PH_RAS  = 2'd1;
    localparam logic [1:0] PH_CAS  = 2'd2;
    localparam logic [1:0] PH_LAST = 2'd3;

endpackage

// File: rtl/vram_slot_timer.sv
module vram_slot_timer
    import vram_seq_pkg::*;
#(
    parameter int AW = 14,
    localparam int MW = AW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  owner_e        owner,
    input  logic [AW-1:0] addr,
    output logic [1:0]    phase,
    output logic          slot_open,
    output logic          cap,
    output logic [MW-1:0] ma,
    output logic          ras_n,
    output logic          cas_n,
    output logic          we_n
);

    typedef struct packed {
        logic [1:0] ph;
    } tmr_t;

    tmr_t tmr_d, tmr_q;
    logic live;

    always_comb begin
        tmr_d    = tmr_q;
        tmr_d.ph = tmr_q.ph + 2'd1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) tmr_q.ph <= PH_LAST;
        else        tmr_q    <= tmr_d;
    end

    assign live      = (owner != OWN_NONE);
    assign phase     = tmr_q.ph;
    assign slot_open = (tmr_q.ph == PH_LAST);
    assign cap       = (tmr_q.ph == PH_CAS);
    assign ma        = tmr_q.ph[1] ? addr[MW-1:0] : addr[AW-1:MW];
    assign ras_n     = !(live && (tmr_q.ph == PH_RAS || tmr_q.ph == PH_CAS));
    assign cas_n     = !(live && tmr_q.ph == PH_CAS);
    assign we_n      = !(owner == OWN_HWR && tmr_q.ph == PH_CAS);

    // R1
    cas_in_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cas_n |-> !ras_n);

    // R1
    cas_after_ras_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cas_n) |-> $past(!ras_n));

endmodule

// File: rtl/vram_addr_gen.sv
module vram_addr_gen #(
    parameter int AW    = 14,
    parameter int PW    = 8,
    parameter int NBASE = 4,
    localparam int BW   = $clog2(NBASE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          base_we,
    input  logic [BW-1:0] base_idx,
    input  logic [AW-1:0] base_val,
    input  logic          fwd,
    input  logic [BW-1:0] bsel,
    input  logic [PW-1:0] ptr,
    input  logic [AW-1:0] dir_addr,
    output logic [AW-1:0] fetch_addr
);

    logic [AW-1:0] base_d [NBASE];
    logic [AW-1:0] base_q [NBASE];

    for (genvar g = 0; g < NBASE; g++) begin : g_base
        always_comb begin
            base_d[g] = base_q[g];
            if (base_we && base_idx == BW'(g)) base_d[g] = base_val;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) base_q[g] <= '0;
            else        base_q[g] <= base_d[g];
        end
    end

    assign fetch_addr = fwd ? (base_q[bsel] + {{(AW-PW){1'b0}}, ptr}) : dir_addr;

    // R4
    base_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        base_we |=> base_q[$past(base_idx)] == $past(base_val));

endmodule

// File: rtl/vram_host_port.sv
module vram_host_port #(
    parameter int AW = 14,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    input  logic          host_aset,
    input  logic [AW-1:0] host_aval,
    input  logic          host_rd,
    input  logic          wr_done,
    input  logic          pf_issue,
    input  logic          pf_cap,
    input  logic [DW-1:0] mdin,
    output logic          busy,
    output logic [DW-1:0] wdata,
    output logic [AW-1:0] ptr,
    output logic          pf_want,
    output logic          rvalid,
    output logic [DW-1:0] rdata
);

    typedef struct packed {
        logic [AW-1:0] ptr;
        logic          busy;
        logic [DW-1:0] wdata;
        logic          pf_pend;
        logic          pf_live;
        logic          rvalid;
        logic [DW-1:0] rdata;
    } hp_t;

    hp_t hp_d, hp_q;

    always_comb begin
        hp_d = hp_q;
        if (host_wr && !hp_q.busy) begin
            hp_d.busy  = 1'b1;
            hp_d.wdata = host_wdata;
        end
        if (wr_done) begin
            hp_d.busy = 1'b0;
            hp_d.ptr  = hp_q.ptr + AW'(1);
        end
        if (pf_issue) begin
            hp_d.pf_pend = 1'b0;
            hp_d.pf_live = 1'b1;
            hp_d.ptr     = hp_q.ptr + AW'(1);
        end
        if (pf_cap && hp_q.pf_live) begin
            hp_d.pf_live = 1'b0;
            hp_d.rvalid  = 1'b1;
            hp_d.rdata   = mdin;
        end
        if (host_rd && hp_q.rvalid) begin
            hp_d.rvalid  = 1'b0;
            hp_d.pf_pend = 1'b1;
        end
        if (host_aset) begin
            hp_d.ptr     = host_aval;
            hp_d.rvalid  = 1'b0;
            hp_d.pf_pend = 1'b1;
            hp_d.pf_live = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hp_q <= '0;
        else        hp_q <= hp_d;
    end

    assign busy    = hp_q.busy;
    assign wdata   = hp_q.wdata;
    assign ptr     = hp_q.ptr;
    assign pf_want = hp_q.pf_pend;
    assign rvalid  = hp_q.rvalid;
    assign rdata   = hp_q.rdata;

    // R6
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hp_q.busy && !wr_done |=> hp_q.busy && $stable(hp_q.wdata));

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hp_q.rvalid && !host_rd && !host_aset |=> hp_q.rvalid && $stable(hp_q.rdata));

endmodule

// File: rtl/vram_seq.sv
module vram_seq
    import vram_seq_pkg::*;
#(
    parameter int AW    = 14,
    parameter int DW    = 8,
    parameter int PW    = 8,
    parameter int NBASE = 4,
    localparam int BW   = $clog2(NBASE),
    localparam int MW   = AW / 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          disp_req,
    input  logic          disp_fwd,
    input  logic [AW-1:0] disp_addr,
    input  logic [PW-1:0] disp_ptr,
    input  logic [BW-1:0] disp_bsel,
    output logic          slot_open,
    output logic          disp_rvalid,
    output logic [DW-1:0] disp_rdata,
    input  logic          base_we,
    input  logic [BW-1:0] base_idx,
    input  logic [AW-1:0] base_val,
    input  logic          host_wr,
    input  logic [DW-1:0] host_wdata,
    output logic          host_busy,
    input  logic          host_aset,
    input  logic [AW-1:0] host_aval,
    input  logic          host_rd,
    output logic          host_rvalid,
    output logic [DW-1:0] host_rdata,
    output logic [MW-1:0] dram_ma,
    output logic          dram_ras_n,
    output logic          dram_cas_n,
    output logic          dram_we_n,
    output logic [DW-1:0] dram_dout,
    input  logic [DW-1:0] dram_din
);

    typedef struct packed {
        owner_e        owner;
        logic [AW-1:0] addr;
        logic          drv;
        logic [DW-1:0] drd;
    } arb_t;

    arb_t arb_d, arb_q;

    logic [1:0]    phase;
    logic          cap;
    logic [AW-1:0] fetch_addr;
    logic [AW-1:0] hptr;
    logic          pf_want;
    logic          pf_issue;
    logic          wr_done;
    logic          pf_cap;

    vram_slot_timer #(.AW(AW)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .owner     (arb_q.owner),
        .addr      (arb_q.addr),
        .phase     (phase),
        .slot_open (slot_open),
        .cap       (cap),
        .ma        (dram_ma),
        .ras_n     (dram_ras_n),
        .cas_n     (dram_cas_n),
        .we_n      (dram_we_n)
    );

    vram_addr_gen #(.AW(AW), .PW(PW), .NBASE(NBASE)) u_agen (
        .clk        (clk),
        .rst_n      (rst_n),
        .base_we    (base_we),
        .base_idx   (base_idx),
        .base_val   (base_val),
        .fwd        (disp_fwd),
        .bsel       (disp_bsel),
        .ptr        (disp_ptr),
        .dir_addr   (disp_addr),
        .fetch_addr (fetch_addr)
    );

    vram_host_port #(.AW(AW), .DW(DW)) u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_wdata (host_wdata),
        .host_aset  (host_aset),
        .host_aval  (host_aval),
        .host_rd    (host_rd),
        .wr_done    (wr_done),
        .pf_issue   (pf_issue),
        .pf_cap     (pf_cap),
        .mdin       (dram_din),
        .busy       (host_busy),
        .wdata      (dram_dout),
        .ptr        (hptr),
        .pf_want    (pf_want),
        .rvalid     (host_rvalid),
        .rdata      (host_rdata)
    );

    assign wr_done  = cap && arb_q.owner == OWN_HWR;
    assign pf_cap   = cap && arb_q.owner == OWN_PF;
    assign pf_issue = slot_open && !disp_req && !host_busy && pf_want && !active;

    always_comb begin
        arb_d     = arb_q;
        arb_d.drv = 1'b0;
        if (cap && arb_q.owner == OWN_DISP) begin
            arb_d.drv = 1'b1;
            arb_d.drd = dram_din;
        end
        if (slot_open) begin
            if (disp_req) begin
                arb_d.owner = OWN_DISP;
                arb_d.addr  = fetch_addr;
            end else if (host_busy) begin
                arb_d.owner = OWN_HWR;
                arb_d.addr  = hptr;
            end else if (pf_issue) begin
                arb_d.owner = OWN_PF;
                arb_d.addr  = hptr;
            end else begin
                arb_d.owner = OWN_NONE;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) arb_q <= '{owner: OWN_NONE, addr: '0, drv: 1'b0, drd: '0};
        else        arb_q <= arb_d;
    end

    assign disp_rvalid = arb_q.drv;
    assign disp_rdata  = arb_q.drd;

    // R2
    disp_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_open && disp_req |=> arb_q.owner == OWN_DISP);

    // R10
    wr_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        slot_open && !disp_req && host_busy |=> arb_q.owner == OWN_HWR);

    // R8
    pf_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_ROW && arb_q.owner == OWN_PF) |-> !$past(active));

    // R5
    we_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dram_we_n |-> host_busy && !dram_cas_n);

endmodule

// File: tb/test_vram_seq.sv
module test_vram_seq;
    timeunit 1ns;
    timeprecision 100ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        active = 1'b1;
    logic        disp_req = 1'b0, disp_fwd = 1'b0;
    logic [13:0] disp_addr = '0;
    logic [7:0]  disp_ptr = '0;
    logic [1:0]  disp_bsel = '0;
    logic        slot_open, disp_rvalid;
    logic [7:0]  disp_rdata;
    logic        base_we = 1'b0;
    logic [1:0]  base_idx = '0;
    logic [13:0] base_val = '0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_wdata = '0;
    logic        host_busy;
    logic        host_aset = 1'b0;
    logic [13:0] host_aval = '0;
    logic        host_rd = 1'b0;
    logic        host_rvalid;
    logic [7:0]  host_rdata;
    logic [6:0]  dram_ma;
    logic        dram_ras_n, dram_cas_n, dram_we_n;
    logic [7:0]  dram_dout, dram_din;

    int checks = 0;
    int fails  = 0;

    logic [7:0] mem [0:16383];
    logic [6:0] row_l = '0;

    always #2.5 clk = ~clk;

    vram_seq i_vram_seq (
        .clk(clk), .rst_n(rst_n), .active(active),
        .disp_req(disp_req), .disp_fwd(disp_fwd), .disp_addr(disp_addr),
        .disp_ptr(disp_ptr), .disp_bsel(disp_bsel), .slot_open(slot_open),
        .disp_rvalid(disp_rvalid), .disp_rdata(disp_rdata),
        .base_we(base_we), .base_idx(base_idx), .base_val(base_val),
        .host_wr(host_wr), .host_wdata(host_wdata), .host_busy(host_busy),
        .host_aset(host_aset), .host_aval(host_aval), .host_rd(host_rd),
        .host_rvalid(host_rvalid), .host_rdata(host_rdata),
        .dram_ma(dram_ma), .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n),
        .dram_we_n(dram_we_n), .dram_dout(dram_dout), .dram_din(dram_din)
    );

    // DRAM model: row latched while the row strobe is high, column on strobe.
    always @(posedge clk) begin
        if (dram_ras_n) row_l <= dram_ma;
        if (!dram_cas_n && !dram_we_n) mem[{row_l, dram_ma}] <= dram_dout;
    end
    assign dram_din = mem[{row_l, dram_ma}];

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wait_open();
        while (!slot_open) @(negedge clk);
    endtask

    task automatic wait_flag(input bit want_busy_low, input string req);
        int n = 0;
        while ((want_busy_low ? host_busy : !host_rvalid) && n < 200) begin
            @(negedge clk);
            n++;
        end
        chk(req, n < 200, 1);
    endtask

    // One display fetch with strobe timing checks.
    task automatic disp_fetch(input bit fwd, input logic [13:0] a, input logic [7:0] p,
                              input logic [1:0] bs, input logic [13:0] exp_a, input string req);
        wait_open();
        disp_req = 1'b1; disp_fwd = fwd; disp_addr = a; disp_ptr = p; disp_bsel = bs;
        @(negedge clk);
        disp_req = 1'b0;
        chk("R1 row phase ras high", dram_ras_n, 1);
        chk("R1 row half", dram_ma, exp_a[13:7]);
        @(negedge clk);
        chk("R1 ras low", {dram_ras_n, dram_cas_n}, 2'b01);
        @(negedge clk);
        chk("R1 cas low", {dram_ras_n, dram_cas_n}, 2'b00);
        chk("R1 column half", dram_ma, exp_a[6:0]);
        @(negedge clk);
        chk("R1 release", {dram_ras_n, dram_cas_n}, 2'b11);
        chk({req, " disp_rvalid"}, disp_rvalid, 1);
        chk({req, " disp_rdata"}, disp_rdata, mem[exp_a]);
    endtask

    task automatic t_reset();
        chk("R12 ras_n", dram_ras_n, 1);
        chk("R12 cas_n", dram_cas_n, 1);
        chk("R12 we_n", dram_we_n, 1);
        chk("R12 busy", host_busy, 0);
        chk("R12 rvalid", host_rvalid, 0);
        chk("R12 disp_rvalid", disp_rvalid, 0);
    endtask

    task automatic t_display();
        disp_fetch(1'b0, 14'h2ABC, 8'h00, 2'd0, 14'h2ABC, "R3 direct");
        disp_fetch(1'b0, 14'h0005, 8'h00, 2'd0, 14'h0005, "R2 back to back");
        @(negedge clk);
        base_we = 1'b1; base_idx = 2'd2; base_val = 14'h3FF8;
        @(negedge clk);
        base_idx = 2'd1; base_val = 14'h1234;
        @(negedge clk);
        base_we = 1'b0;
        disp_fetch(1'b1, 14'h0000, 8'hF0, 2'd2, 14'h00E8, "R3 R4 forwarded wrap");
        disp_fetch(1'b1, 14'h0000, 8'h05, 2'd1, 14'h1239, "R3 R4 forwarded base1");
    endtask

    task automatic t_writes();
        logic [7:0] keep;
        keep = mem[14'h0202];
        active = 1'b1;
        @(negedge clk);
        host_aset = 1'b1; host_aval = 14'h0200;
        @(negedge clk);
        host_aset = 1'b0;
        while (slot_open) @(negedge clk);
        host_wr = 1'b1; host_wdata = 8'hA5;
        @(negedge clk);
        host_wr = 1'b0;
        chk("R5 busy rises", host_busy, 1);
        host_wr = 1'b1; host_wdata = 8'h5A;
        @(negedge clk);
        host_wr = 1'b0;
        // display holds three slots while the write waits
        disp_fetch(1'b0, 14'h0100, 8'h00, 2'd0, 14'h0100, "R2 under host load a");
        disp_fetch(1'b0, 14'h0101, 8'h00, 2'd0, 14'h0101, "R2 under host load b");
        disp_fetch(1'b0, 14'h0102, 8'h00, 2'd0, 14'h0102, "R2 under host load c");
        chk("R2 write still waiting", host_busy, 1);
        chk("R2 memory untouched", mem[14'h0200] == 8'hA5, 0);
        wait_flag(1'b1, "R5 write completes");
        chk("R5 data written", mem[14'h0200], 8'hA5);
        while (slot_open) @(negedge clk);
        host_wr = 1'b1; host_wdata = 8'h3C;
        @(negedge clk);
        host_wr = 1'b0;
        wait_flag(1'b1, "R5 second write completes");
        chk("R6 R7 next address", mem[14'h0201], 8'h3C);
        chk("R6 stalled write dropped", mem[14'h0202], keep);
        repeat (12) @(negedge clk);
        chk("R8 no prefetch in picture", host_rvalid, 0);
        active = 1'b0;
        wait_flag(1'b0, "R8 prefetch in blanking");
        chk("R7 R8 prefetch at pointer", host_rdata, mem[14'h0202]);
    endtask

    task automatic t_reads();
        active = 1'b0;
        @(negedge clk);
        host_aset = 1'b1; host_aval = 14'h1000;
        @(negedge clk);
        host_aset = 1'b0;
        wait_flag(1'b0, "R9 first fill");
        chk("R9 first byte", host_rdata, mem[14'h1000]);
        for (int k = 1; k < 5; k++) begin
            host_rd = 1'b1;
            @(negedge clk);
            chk("R9 buffer emptied", host_rvalid, 0);
            // R11: extra read while empty must not skip an address
            @(negedge clk);
            host_rd = 1'b0;
            wait_flag(1'b0, "R9 refill");
            chk("R9 R11 sequential byte", host_rdata, mem[14'h1000 + 14'(k)]);
        end
    endtask

    task automatic t_order();
        logic [7:0] old300;
        old300 = mem[14'h0300];
        active = 1'b0;
        @(negedge clk);
        while (slot_open) @(negedge clk);
        host_aset = 1'b1; host_aval = 14'h0300;
        host_wr = 1'b1; host_wdata = 8'h77;
        @(negedge clk);
        host_aset = 1'b0; host_wr = 1'b0;
        wait_flag(1'b0, "R10 fill after write");
        chk("R10 write landed first", mem[14'h0300], 8'h77);
        chk("R10 prefetch after write", host_rdata, mem[14'h0301]);
        chk("R10 not stale byte", host_rdata == old300 && old300 != mem[14'h0301], 0);
    endtask

    initial begin
        for (int a = 0; a < 16384; a++) mem[a] = 8'((a * 37) ^ (a >> 6));
        repeat (4) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_display();
        t_writes();
        t_reads();
        t_order();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end

endmodule